// File: doc/BRIEF.md
# Prescaled Edge Counter with Fixed-Width Pulse Output

This block watches an asynchronous event line and counts its rising edges entirely inside one system clock domain. The event line is never used as a clock. It is first brought into the clock domain by a short flop chain. A registered detector then turns each low-to-high transition into a strobe that lasts one cycle. A prescale counter advances on every strobe. When the counter reaches the value selected on the prescale input, it wraps to zero and fires a trigger.

Each trigger loads a down-counting pulse timer. The single output stays high while that timer is nonzero. At the default setting the pulse is 50 system clocks long, which is 1 µs on a 50 MHz clock. A trigger that arrives while a pulse is still running reloads the timer, so the pulse is stretched rather than doubled. The prescale input comes from already-debounced switches. It can change at any time without clearing the running count.

Top module: `edge_prescaler`

## Requirements
- R1: While `rst_n` is low, `pulse_out` is low and the edge count is cleared. After release, counting starts again from zero.
- R2: For a prescale value N from 2 to 255, exactly one pulse is produced for every N rising edges of `event_in`.
- R3: Each pulse that is not retriggered is high for exactly PULSE_CYCLES (default 50) consecutive clock cycles.
- R4: A prescale value of 0 or of 1 produces one pulse for every rising edge of `event_in`.
- R5: A trigger that arrives while a pulse is active restarts the pulse timer. The output then stays high until PULSE_CYCLES cycles after the latest trigger.
- R6: Changing the prescale value does not clear the count. If the count is already at or above the new N-1, the next detected edge wraps the count to zero and fires a pulse.
- R7: When `event_in` rises and is settled before a clock edge, `pulse_out` goes high after the fourth rising clock edge counted from that one, with the default two-stage synchronizer and a trigger-producing edge.
- R8: A rising edge of `event_in` is counted once, however long the line then stays high. The internal edge strobe never lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_in | input | 1 | Asynchronous event line whose rising edges are counted |
| prescale_sel | input | PRESCALE_W (8) | Prescale value N; 0 and 1 both mean divide by one |
| pulse_out | output | 1 | High for PULSE_CYCLES clocks after each terminal count |

## Verification
The bench builds the block with its defaults: an 8-bit prescale value, a 50-cycle pulse and a two-stage synchronizer. The 8-bit width brings the largest divide ratio, 255, within reach in about a thousand cycles. The 50-cycle pulse is short enough that triggers spaced 20 cycles apart overlap it, which exercises the retrigger stretch. The fixed synchronizer depth makes the edge-to-pulse latency an exact number that the bench can check. The scoreboard records every expected pulse length together with a running pulse total. With that, an extra or missing pulse after a prescale change or a reset in mid-count shows up as a mismatch.

// File: rtl/edge_prescaler_pkg.sv
package edge_prescaler_pkg;

  // Terminal test for the prescale counter: values 0 and 1 divide by one,
  // otherwise the count wraps once it has reached n-1 (or passed it).
  function automatic logic ps_at_terminal(input int unsigned cnt, input int unsigned n);
    if (n <= 1) return 1'b1;
    return (cnt >= n - 1);
  endfunction

  // Bits needed to hold a pulse length of `cycles`.
  function automatic int unsigned ps_timer_width(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic event_in,
  output logic edge_stb
);

  logic synced;
  logic prev_q;
  logic stb_q;

  generate
    if (SYNC_STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= event_in;
      end
      assign synced = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], event_in};
      end
      assign synced = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  // Registered rising-edge strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      prev_q <= synced;
      stb_q  <= synced & ~prev_q;
    end
  end

  assign edge_stb = stb_q;

  // R8
  edge_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |=> !edge_stb);

endmodule

// File: rtl/prescale_counter.sv
module prescale_counter
  import edge_prescaler_pkg::*;
#(
  parameter int PRESCALE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  edge_stb,
  input  logic [PRESCALE_W-1:0] prescale_n,
  output logic [PRESCALE_W-1:0] count,
  output logic                  fire
);

  logic [PRESCALE_W-1:0] cnt_q;
  logic                  at_term;

  assign at_term = ps_at_terminal(32'(cnt_q), 32'(prescale_n));
  assign fire    = edge_stb & at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (fire)     cnt_q <= '0;
    else if (edge_stb) cnt_q <= cnt_q + PRESCALE_W'(1);
  end

  assign count = cnt_q;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_stb |=> $stable(cnt_q));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb && !fire) |=> (cnt_q == $past(cnt_q) + PRESCALE_W'(1)));

  // R6
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == '0));

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import edge_prescaler_pkg::*;
#(
  parameter int PULSE_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_out
);

  localparam int TW = ps_timer_width(PULSE_CYCLES);

  logic [TW-1:0] timer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              timer_q <= '0;
    else if (fire)           timer_q <= TW'(PULSE_CYCLES);
    else if (timer_q != '0)  timer_q <= timer_q - TW'(1);
  end

  assign pulse_out = (timer_q != '0);

  // R3
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_out) |-> $past(fire));

  // R5
  timer_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && timer_q != '0) |=> (timer_q == $past(timer_q) - TW'(1)));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> !pulse_out);

endmodule

// File: rtl/edge_prescaler.sv
module edge_prescaler
  import edge_prescaler_pkg::*;
#(
  parameter int PRESCALE_W   = 8,
  parameter int PULSE_CYCLES = 50,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  event_in,
  input  logic [PRESCALE_W-1:0] prescale_sel,
  output logic                  pulse_out
);

  // Named internal events, kept visible for the assertions
  logic                  edge_stb;
  logic                  fire;
  logic [PRESCALE_W-1:0] count;

  sync_edge_det #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_in (event_in),
    .edge_stb (edge_stb)
  );

  prescale_counter #(
    .PRESCALE_W(PRESCALE_W)
  ) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_stb   (edge_stb),
    .prescale_n (prescale_sel),
    .count      (count),
    .fire       (fire)
  );

  pulse_timer #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .pulse_out (pulse_out)
  );

  // R4
  div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_stb && prescale_sel <= PRESCALE_W'(1)) |-> fire);

  // R6
  no_early_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (prescale_sel <= PRESCALE_W'(1) || 32'(count) + 1 >= 32'(prescale_sel)));

endmodule

// File: tb/edge_prescaler_test.sv
module edge_prescaler_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       event_in = 1'b0;
  logic [7:0] prescale_sel = 8'd8;
  logic       pulse_out;

  always #2 clk = ~clk;

  edge_prescaler uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .event_in     (event_in),
    .prescale_sel (prescale_sel),
    .pulse_out    (pulse_out)
  );

  typedef struct {
    int    len;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails = 0;
  int   run = 0;
  int   seen = 0;
  int   expected_total = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic expect_pulse(input int len, input string tag);
    exp_t e;
    e.len = len;
    e.tag = tag;
    exp_q.push_back(e);
    expected_total++;
  endtask

  task automatic send_edges(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) event_in = 1'b1;
      repeat (hi) @(negedge clk);
      event_in = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  task automatic settle_and_count(input string tag);
    repeat (90) @(negedge clk);
    check(seen == expected_total, tag, "pulse total", seen, expected_total);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Monitor: measures each high run of pulse_out and compares it with the queue
  always @(negedge clk) begin : monitor
    exp_t e;
    if (!rst_n) begin
      run = 0;
    end else if (pulse_out) begin
      run++;
    end else if (run > 0) begin
      seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected pulse of length", run, 0);
      end else begin
        e = exp_q.pop_front();
        check(run == e.len, e.tag, "pulse length", run, e.len);
      end
      run = 0;
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin : driver
    int lat;
    repeat (3) @(negedge clk);
    // R1: output low in reset
    check(pulse_out == 1'b0, "R1", "pulse_out in reset", int'(pulse_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(pulse_out == 1'b0, "R1", "pulse_out after release", int'(pulse_out), 0);

    // R2: divide by 8, 16 edges -> 2 pulses of 50 (R3)
    prescale_sel = 8'd8;
    expect_pulse(50, "R3");
    expect_pulse(50, "R3");
    send_edges(16, 4, 4);
    settle_and_count("R2");

    // R2: divide by 3, 6 edges -> 2 pulses
    prescale_sel = 8'd3;
    expect_pulse(50, "R2");
    expect_pulse(50, "R2");
    send_edges(6, 10, 10);
    settle_and_count("R2");

    // R7 latency and R8 long high level counted once (divide by 1, R4)
    prescale_sel = 8'd1;
    expect_pulse(50, "R8");
    @(negedge clk) event_in = 1'b1;
    lat = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (pulse_out && lat == 0) lat = i;
    end
    check(lat == 4, "R7", "edges to pulse_out high", lat, 4);
    repeat (92) @(negedge clk);
    event_in = 1'b0;
    settle_and_count("R8");

    // R4: divide by 1, three edges -> three pulses
    expect_pulse(50, "R4");
    expect_pulse(50, "R4");
    expect_pulse(50, "R4");
    send_edges(3, 30, 30);
    settle_and_count("R4");

    // R4: value 0 behaves as divide by 1
    prescale_sel = 8'd0;
    expect_pulse(50, "R4");
    expect_pulse(50, "R4");
    send_edges(2, 30, 30);
    settle_and_count("R4");

    // R5: two triggers 20 cycles apart -> one stretched pulse of 70
    prescale_sel = 8'd1;
    expect_pulse(70, "R5");
    send_edges(2, 10, 10);
    settle_and_count("R5");

    // R6: count 5 at divide by 8, then switch to 4: next edge wraps
    prescale_sel = 8'd8;
    send_edges(5, 4, 4);
    settle_and_count("R6");
    prescale_sel = 8'd4;
    expect_pulse(50, "R6");
    send_edges(1, 4, 4);
    settle_and_count("R6");
    send_edges(3, 4, 4);
    settle_and_count("R6");
    expect_pulse(50, "R6");
    send_edges(1, 4, 4);
    settle_and_count("R6");

    // R1: reset mid-count clears the count
    prescale_sel = 8'd8;
    send_edges(5, 4, 4);
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(pulse_out == 1'b0, "R1", "pulse_out during mid-count reset", int'(pulse_out), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    send_edges(7, 4, 4);
    settle_and_count("R1");
    expect_pulse(50, "R1");
    send_edges(1, 4, 4);
    settle_and_count("R1");

    // R2: largest ratio, 255
    prescale_sel = 8'd255;
    send_edges(254, 2, 2);
    settle_and_count("R2");
    expect_pulse(50, "R2");
    send_edges(1, 2, 2);
    settle_and_count("R2");

    check(exp_q.size() == 0, "R2", "pulses still expected", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule